// File: doc/BRIEF.md
# Software-Driven Two-Wire Bus Register Port

This block is a small set of memory-mapped registers through which a processor runs a two-wire serial bus (I2C) entirely in software. There is no protocol engine inside: each register write to the line-control register sets the clock and data wire levels directly. A read of the line-sense register returns the live level of the data wire as driven by the attached target device. Software builds start and stop conditions, data bits and acknowledge slots by issuing these accesses in the right order.

Alongside the line registers, the block has four more registers: a direction-enable register, a bus-select bit, a general-purpose byte output and a break byte. The processor side is a plain synchronous port with address, write data, write strobe, read strobe and registered read data.

Top module: `i2cbb_port`

## Requirements
- R1: After reset, reads return 0x0A at break offset 0xA10, 0x00 at general-purpose offset 0xA00, 0x0 at enable offset 0xB08, 0x03 at line-control offset 0xB10 and 0x1 at select offset 0xB18. Both wire outputs are high.
- R2: A write to offset 0xB10 sets the clock output from write-data bit 1 and the data output from bit 0, starting right after the accepting clock edge. All 32 written bits read back unchanged.
- R3: A read of offset 0xB00 returns the constant 0x00000003 with bit 0 replaced by the data-input level present in the read cycle. Writes to 0xB00 have no effect.
- R4: The select register at 0xB18 stores only bit 0 of a write, and the other bits read as zero.
- R5: The general-purpose register at 0xA00 stores only bits 7:0 of a write.
- R6: The break register at 0xA10 stores only bits 7:0 of a write.
- R7: The enable register at 0xB08 stores only bits 1:0 of a write.
- R8: A read of any other offset returns zero, and a write to any other offset changes no register and no wire output.
- R9: Read data appears one cycle after the cycle that presents a read strobe. In a cycle that follows one without a read strobe, read data is zero.
- R10: The clock and data outputs keep their values in every cycle that does not contain a write to offset 0xB10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| scl_o | output | 1 | Bus clock wire level |
| sda_o | output | 1 | Bus data wire level |
| sda_in | input | 1 | Data wire level seen from the target |

## Verification
Read data is due exactly one cycle after the strobe. The bench's driver queues the expected word when it issues a read. The monitor takes the strobe at the rising edge and compares rdata two nanoseconds later, in the same cycle. Wire outputs are due on the first falling edge after the edge that accepts a write, and they are checked there; the no-effect cases read back every register immediately afterwards. The data-input level is set in the same half cycle as the read, so the expected bit 0 is the level in that cycle.

// File: rtl/i2cbb_pkg.sv
package i2cbb_pkg;

    localparam int REG_W  = 32;
    localparam int BYTE_W = 8;
    localparam int OE_W   = 2;

    // constant content of the line-sense register (bit 0 is replaced live)
    localparam logic [REG_W-1:0] SENSE_BASE = 32'h0000_0003;

    localparam logic [BYTE_W-1:0] BRK_RST  = 8'h0A;
    localparam logic [BYTE_W-1:0] GPO_RST  = 8'h00;
    localparam logic [OE_W-1:0]   OE_RST   = 2'b00;
    localparam logic [REG_W-1:0]  LINE_RST = 32'h0000_0003;
    localparam logic              SEL_RST  = 1'b1;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_GPO,
        RS_BRK,
        RS_SENSE,
        RS_OE,
        RS_LINE,
        RS_SEL
    } regsel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] gpo;
        logic [BYTE_W-1:0] brk;
        logic [OE_W-1:0]   oe;
        logic [REG_W-1:0]  line;
        logic              sel;
    } regs_t;

endpackage

// File: rtl/i2cbb_decode.sv
module i2cbb_decode
    import i2cbb_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] OFF_GPO   = 12'hA00,
    parameter logic [11:0] OFF_BRK   = 12'hA10,
    parameter logic [11:0] OFF_SENSE = 12'hB00,
    parameter logic [11:0] OFF_OE    = 12'hB08,
    parameter logic [11:0] OFF_LINE  = 12'hB10,
    parameter logic [11:0] OFF_SEL   = 12'hB18
) (
    input  logic [ADDR_W-1:0] addr,
    output regsel_e           sel
);

    always_comb begin
        sel = RS_NONE;
        if      (addr == ADDR_W'(OFF_GPO))   sel = RS_GPO;
        else if (addr == ADDR_W'(OFF_BRK))   sel = RS_BRK;
        else if (addr == ADDR_W'(OFF_SENSE)) sel = RS_SENSE;
        else if (addr == ADDR_W'(OFF_OE))    sel = RS_OE;
        else if (addr == ADDR_W'(OFF_LINE))  sel = RS_LINE;
        else if (addr == ADDR_W'(OFF_SEL))   sel = RS_SEL;
    end

endmodule

// File: rtl/i2cbb_regs.sv
module i2cbb_regs
    import i2cbb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  regsel_e          sel,
    input  logic [REG_W-1:0] wdata,
    output regs_t            regs
);

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (sel)
                RS_GPO:  regs_d.gpo  = wdata[BYTE_W-1:0];
                RS_BRK:  regs_d.brk  = wdata[BYTE_W-1:0];
                RS_OE:   regs_d.oe   = wdata[OE_W-1:0];
                RS_LINE: regs_d.line = wdata;
                RS_SEL:  regs_d.sel  = wdata[0];
                default: regs_d = regs_q; // sense register and holes
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.gpo  <= GPO_RST;
            regs_q.brk  <= BRK_RST;
            regs_q.oe   <= OE_RST;
            regs_q.line <= LINE_RST;
            regs_q.sel  <= SEL_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/i2cbb_rdmux.sv
module i2cbb_rdmux
    import i2cbb_pkg::*;
(
    input  regsel_e          sel,
    input  regs_t            regs,
    input  logic             sda_in,
    output logic [REG_W-1:0] rd_word
);

    always_comb begin
        rd_word = '0;
        case (sel)
            RS_GPO:   rd_word = REG_W'(regs.gpo);
            RS_BRK:   rd_word = REG_W'(regs.brk);
            RS_SENSE: rd_word = {SENSE_BASE[REG_W-1:1], sda_in};
            RS_OE:    rd_word = REG_W'(regs.oe);
            RS_LINE:  rd_word = regs.line;
            RS_SEL:   rd_word = REG_W'(regs.sel);
            default:  rd_word = '0;
        endcase
    end

endmodule

// File: rtl/i2cbb_port.sv
module i2cbb_port
    import i2cbb_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] OFF_GPO   = 12'hA00,
    parameter logic [11:0] OFF_BRK   = 12'hA10,
    parameter logic [11:0] OFF_SENSE = 12'hB00,
    parameter logic [11:0] OFF_OE    = 12'hB08,
    parameter logic [11:0] OFF_LINE  = 12'hB10,
    parameter logic [11:0] OFF_SEL   = 12'hB18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [REG_W-1:0]  rdata,
    output logic              scl_o,
    output logic              sda_o,
    input  logic              sda_in
);

    localparam int SCL_BIT = 1;
    localparam int SDA_BIT = 0;

    regsel_e          sel;
    regs_t            regs;
    logic [REG_W-1:0] rd_word;
    logic [REG_W-1:0] rdata_d, rdata_q;

    i2cbb_decode #(
        .ADDR_W   (ADDR_W),
        .OFF_GPO  (OFF_GPO),
        .OFF_BRK  (OFF_BRK),
        .OFF_SENSE(OFF_SENSE),
        .OFF_OE   (OFF_OE),
        .OFF_LINE (OFF_LINE),
        .OFF_SEL  (OFF_SEL)
    ) u_dec (
        .addr(addr),
        .sel (sel)
    );

    i2cbb_regs u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .sel  (sel),
        .wdata(wdata),
        .regs (regs)
    );

    i2cbb_rdmux u_mux (
        .sel    (sel),
        .regs   (regs),
        .sda_in (sda_in),
        .rd_word(rd_word)
    );

    always_comb begin
        rdata_d = rd_en ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
    assign scl_o = regs.line[SCL_BIT];
    assign sda_o = regs.line[SDA_BIT];

endmodule

// File: rtl/i2cbb_port_chk.sv
module i2cbb_port_chk #(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] OFF_GPO   = 12'hA00,
    parameter logic [11:0] OFF_BRK   = 12'hA10,
    parameter logic [11:0] OFF_SENSE = 12'hB00,
    parameter logic [11:0] OFF_OE    = 12'hB08,
    parameter logic [11:0] OFF_LINE  = 12'hB10,
    parameter logic [11:0] OFF_SEL   = 12'hB18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rdata,
    input logic              scl_o,
    input logic              sda_o,
    input logic              sda_in
);

    logic hit_line, hit_sense, hit_any;
    assign hit_line  = (addr == ADDR_W'(OFF_LINE));
    assign hit_sense = (addr == ADDR_W'(OFF_SENSE));
    assign hit_any   = (addr == ADDR_W'(OFF_GPO))  || (addr == ADDR_W'(OFF_BRK)) ||
                       hit_sense || (addr == ADDR_W'(OFF_OE)) ||
                       hit_line  || (addr == ADDR_W'(OFF_SEL));

    // R2: wire levels follow the accepted write
    assert_line_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_line) |=> (scl_o == $past(wdata[1]) && sda_o == $past(wdata[0])));

    // R10: no line write, no wire movement
    assert_wires_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_line) |=> ($stable(scl_o) && $stable(sda_o)));

    // R9: idle cycle gives zero read data
    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == 32'h0));

    // R8: holes read zero
    assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_any) |=> (rdata == 32'h0));

    // R3: sense register carries the live data level
    assert_sense_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_sense) |=> (rdata == {31'h1, $past(sda_in)}));

endmodule

bind i2cbb_port i2cbb_port_chk #(
    .ADDR_W   (ADDR_W),
    .OFF_GPO  (OFF_GPO),
    .OFF_BRK  (OFF_BRK),
    .OFF_SENSE(OFF_SENSE),
    .OFF_OE   (OFF_OE),
    .OFF_LINE (OFF_LINE),
    .OFF_SEL  (OFF_SEL)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wdata (wdata),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .scl_o (scl_o),
    .sda_o (sda_o),
    .sda_in(sda_in)
);

// File: tb/sim_i2cbb_port.sv
module sim_i2cbb_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        scl_o, sda_o;
    logic        sda_in = 1'b1;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    i2cbb_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .scl_o(scl_o), .sda_o(sda_o), .sda_in(sda_in)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // driver: one access per cycle, issued on the falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1; wr_en = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: read data due in the cycle after the strobe
    initial begin
        forever begin
            logic was_rd;
            @(posedge clk);
            was_rd = rd_en;
            #2;
            if (was_rd && exp_q.size() > 0) chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
    end

    task automatic read_all(input logic [31:0] gpo, input logic [31:0] brk,
                            input logic [31:0] oe, input logic [31:0] line,
                            input logic [31:0] sel, input string tag);
        rd(12'hA00, gpo,  {tag, " gpo"});
        rd(12'hA10, brk,  {tag, " brk"});
        rd(12'hB08, oe,   {tag, " oe"});
        rd(12'hB10, line, {tag, " line"});
        rd(12'hB18, sel,  {tag, " sel"});
    endtask

    initial begin
        #150000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 scl", {31'h0, scl_o}, 32'h1);
        chk("R1 sda", {31'h0, sda_o}, 32'h1);
        read_all(32'h00, 32'h0A, 32'h0, 32'h3, 32'h1, "R1 reset");

        // R9 idle read data zero
        @(negedge clk);
        chk("R9 idle", rdata, 32'h0);

        // R2 / R10 line writes
        wr(12'hB10, 32'hDEAD_BEE1);
        chk("R2 scl", {31'h0, scl_o}, 32'h0);
        chk("R2 sda", {31'h0, sda_o}, 32'h1);
        rd(12'hB10, 32'hDEAD_BEE1, "R2 readback");
        wr(12'hB10, 32'h0000_0002);
        chk("R2 scl2", {31'h0, scl_o}, 32'h1);
        chk("R2 sda2", {31'h0, sda_o}, 32'h0);
        wr(12'hA00, 32'hFFFF_FFFF);
        chk("R10 scl", {31'h0, scl_o}, 32'h1);
        chk("R10 sda", {31'h0, sda_o}, 32'h0);

        // R3 sense with both levels, and ignored write
        sda_in = 1'b0;
        rd(12'hB00, 32'h2, "R3 sda0");
        sda_in = 1'b1;
        rd(12'hB00, 32'h3, "R3 sda1");
        wr(12'hB00, 32'h0);
        sda_in = 1'b0;
        rd(12'hB00, 32'h2, "R3 after write");

        // R4..R7 masking
        wr(12'hB18, 32'hFFFF_FFFE);
        rd(12'hB18, 32'h0, "R4 sel0");
        wr(12'hB18, 32'h0000_0003);
        rd(12'hB18, 32'h1, "R4 sel1");
        rd(12'hA00, 32'hFF, "R5 gpo");
        wr(12'hA00, 32'h1234_5A5C);
        rd(12'hA00, 32'h5C, "R5 gpo2");
        wr(12'hA10, 32'hABCD_EF37);
        rd(12'hA10, 32'h37, "R6 brk");
        wr(12'hB08, 32'hFFFF_FFFF);
        rd(12'hB08, 32'h3, "R7 oe");
        wr(12'hB08, 32'h0000_0005);
        rd(12'hB08, 32'h1, "R7 oe2");

        // R8 holes
        rd(12'h000, 32'h0, "R8 hole0");
        rd(12'hB04, 32'h0, "R8 holeB04");
        wr(12'hB14, 32'h0000_0001);
        wr(12'hA04, 32'h0000_00AA);
        chk("R8 scl", {31'h0, scl_o}, 32'h1);
        chk("R8 sda", {31'h0, sda_o}, 32'h0);
        read_all(32'h5C, 32'h37, 32'h1, 32'h2, 32'h1, "R8 after hole writes");

        // R9 back-to-back reads
        @(negedge clk);
        addr = 12'hA10; rd_en = 1'b1;
        exp_q.push_back(32'h37); tag_q.push_back("R9 b2b first");
        @(negedge clk);
        addr = 12'hB10;
        exp_q.push_back(32'h2); tag_q.push_back("R9 b2b second");
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R9 idle after", rdata, 32'h0);

        repeat (3) @(negedge clk);
        chk("queue drained", exp_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule